// File: doc/BRIEF.md
# Single-Shot Key Press Registrar

This block sits behind a matrix keypad scanner. It watches the scanner's "some key is down" flag and the key code the scanner reports. It turns each physical press into exactly one registration event. A press counts only after the down flag has been seen on a set number of consecutive scan ticks. At that point the block stores the key code and raises a pulse that lasts one clock cycle.

After a registration, the block ignores the keypad until every key has been let go. The release must also stay steady for the same number of consecutive ticks. Only then does the block arm again. Contact bounce on press and on release therefore cannot produce extra events. A second key pressed while the first is still held is never registered.

Downstream logic, such as a key history or a display, updates only on the pulse and reads the stored code.

Top module: `key_press_registrar`

## Requirements
- R1: `new_key` is high for exactly one clock cycle per registration. In that cycle `captured_key` equals the `key_code` value sampled at the clock edge that completed the registration.
- R2: A press registers only when `any_pressed` is sampled high together with `scan_tick` on STABLE_TICKS consecutive ticks (default 2). Cycles without `scan_tick` neither advance nor break the count, so a press held without ticks never registers.
- R3: If `any_pressed` is low on a tick before the count reaches STABLE_TICKS, the block returns to idle and emits no pulse.
- R4: After a registration and while any key is down, no pulse is emitted, whatever `key_code` does (for example, a second key).
- R5: The block re-arms only after `any_pressed` has been low on STABLE_TICKS consecutive ticks. A tick with `any_pressed` high during that wait restarts the release count.
- R6: `captured_key` changes only in a cycle where `new_key` is high. Otherwise it keeps the last registered code.
- R7: With `rst_n` low at a clock edge, the block goes idle, with `new_key` at 0 and `captured_key` at 0.
- R8: `new_key` rises in the cycle right after the clock edge at which the final qualifying tick is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_tick | input | 1 | One-cycle scan-rate enable; debounce counts advance only on it |
| any_pressed | input | 1 | High while the scanner sees any key down |
| key_code | input | KEY_W | Code of the key the scanner currently reports |
| new_key | output | 1 | One-cycle registration pulse |
| captured_key | output | KEY_W | Code stored at the last registration |

## Verification
The bench aims at presses that bounce for fewer ticks than the threshold. A design that registers too early would emit pulses for them. It also sends release bounce that reappears just before the release count completes. A design that re-arms too early would then register the same press twice. Changing the key code while a key is held catches a block that re-registers or overwrites the stored code. Holding the press flag with no ticks, and resetting in the middle of a hold, expose a count that ignores the tick enable and a reset that leaves a pulse or a stale code behind.

// File: rtl/kpr_pkg.sv
// Shared types for the key press registrar.
package kpr_pkg;
    // Control states: waiting, counting a press, firing, waiting for release.
    typedef enum logic [1:0] {
        KPR_IDLE   = 2'd0,
        KPR_SETTLE = 2'd1,
        KPR_FIRE   = 2'd2,
        KPR_DRAIN  = 2'd3
    } kpr_state_e;
endpackage

// File: rtl/kpr_run_counter.sv
// Counts consecutive qualifying ticks.
// at_last is high when one more increment would reach RUN_LEN.
// Assumes RUN_LEN >= 1; the controller decides when to clear and when to advance.
module kpr_run_counter #(
    parameter int RUN_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int CNT_W = (RUN_LEN < 2) ? 1 : $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    // Run length register: clear has priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the point where the next qualifying tick completes the run.
    assign at_last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/kpr_ctrl.sv
// Registration controller.
// It qualifies presses and releases on scan ticks and requests the code capture.
// It drives the one-cycle pulse from a flop.
// Assumes the run counter reports at_last for the current run length.
module kpr_ctrl
    import kpr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pressed,
    input  logic at_last,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic load,
    output logic fire_q
);
    kpr_state_e state_q, state_d;

    // Next state and counter control.
    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            KPR_IDLE: begin
                if (tick && pressed) begin
                    if (at_last) begin
                        state_d = KPR_FIRE;
                        cnt_clr = 1'b1;
                    end else begin
                        state_d = KPR_SETTLE;
                        cnt_inc = 1'b1;
                    end
                end else begin
                    cnt_clr = 1'b1;
                end
            end
            KPR_SETTLE: begin
                if (tick) begin
                    if (!pressed) begin
                        state_d = KPR_IDLE;
                        cnt_clr = 1'b1;
                    end else if (at_last) begin
                        state_d = KPR_FIRE;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            KPR_FIRE: begin
                state_d = KPR_DRAIN;
                cnt_clr = 1'b1;
            end
            KPR_DRAIN: begin
                if (tick) begin
                    if (pressed) begin
                        cnt_clr = 1'b1;
                    end else if (at_last) begin
                        state_d = KPR_IDLE;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            default: begin
                state_d = KPR_IDLE;
                cnt_clr = 1'b1;
            end
        endcase
    end

    // Capture the code on the cycle that enters the firing state.
    assign load = (state_d == KPR_FIRE);

    // State and registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KPR_IDLE;
            fire_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fire_q  <= (state_d == KPR_FIRE);
        end
    end
endmodule

// File: rtl/kpr_capture.sv
// Holds the key code of the last registration.
// Loads only when the controller requests it; clears on reset.
module kpr_capture #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Code holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/key_press_registrar.sv
// Top level: turns each debounced key press into a single registration pulse.
// Assumes scan_tick is a one-cycle enable at the scan rate and that
// key_code is valid whenever any_pressed is high.
module key_press_registrar #(
    parameter int KEY_W        = 4,
    parameter int STABLE_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_tick,
    input  logic             any_pressed,
    input  logic [KEY_W-1:0] key_code,
    output logic             new_key,
    output logic [KEY_W-1:0] captured_key
);
    logic cnt_clr, cnt_inc, at_last, load;

    kpr_run_counter #(.RUN_LEN(STABLE_TICKS)) run_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .at_last (at_last)
    );

    kpr_ctrl ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (scan_tick),
        .pressed (any_pressed),
        .at_last (at_last),
        .cnt_clr (cnt_clr),
        .cnt_inc (cnt_inc),
        .load    (load),
        .fire_q  (new_key)
    );

    kpr_capture #(.WIDTH(KEY_W)) cap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (key_code),
        .q     (captured_key)
    );
endmodule

// File: rtl/key_press_registrar_checker.sv
// Port-level properties of the registrar, attached through bind.
module key_press_registrar_checker #(
    parameter int KEY_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scan_tick,
    input logic             any_pressed,
    input logic [KEY_W-1:0] key_code,
    input logic             new_key,
    input logic [KEY_W-1:0] captured_key
);
    logic past_valid = 1'b0;

    // Marks that at least one clock edge has happened.
    always_ff @(posedge clk) past_valid <= 1'b1;

    // R1: the pulse never lasts two cycles.
    p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        new_key |=> !new_key);

    // R1: the stored code is the one sampled at the registering edge.
    p_capture_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(new_key) |-> captured_key == $past(key_code));

    // R2: a pulse follows only a sampled tick with the press flag high.
    p_tick_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && new_key) |-> ($past(scan_tick) && $past(any_pressed)));

    // R6: the stored code moves only together with the pulse.
    p_code_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && !new_key) |-> $stable(captured_key));

    // R7: a reset edge leaves the outputs cleared.
    p_reset_clear_r7: assert property (@(posedge clk)
        (past_valid && !$past(rst_n)) |-> (!new_key && captured_key == '0));
endmodule

bind key_press_registrar key_press_registrar_checker #(.KEY_W(KEY_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .scan_tick    (scan_tick),
    .any_pressed  (any_pressed),
    .key_code     (key_code),
    .new_key      (new_key),
    .captured_key (captured_key)
);

// File: tb/key_press_registrar_tb_top.sv
// Self-checking bench for the key press registrar.
module key_press_registrar_tb_top;
    localparam int KEY_W = 4;
    localparam int N     = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             scan_tick = 1'b0;
    logic             any_pressed = 1'b0;
    logic [KEY_W-1:0] key_code = '0;
    logic             new_key;
    logic [KEY_W-1:0] captured_key;

    int checks = 0;
    int failures = 0;
    int pulse_cnt = 0;
    int wide_cnt = 0;
    logic prev_pulse = 1'b0;
    bit done = 1'b0;

    key_press_registrar #(.KEY_W(KEY_W), .STABLE_TICKS(N)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scan_tick    (scan_tick),
        .any_pressed  (any_pressed),
        .key_code     (key_code),
        .new_key      (new_key),
        .captured_key (captured_key)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (new_key) begin
                pulse_cnt = pulse_cnt + 1;
                if (prev_pulse) wide_cnt = wide_cnt + 1;
            end
            prev_pulse = new_key;
        end else begin
            prev_pulse = 1'b0;
        end
    end

    // Expected pulses for a press held over a given number of ticks.
    function automatic int exp_pulses(input int held_ticks);
        return (held_ticks >= N) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One scan tick with the given inputs, then idle cycles; returns new_key
    // sampled in the cycle after the tick edge.
    task automatic tick_once(input logic prs, input logic [KEY_W-1:0] code,
                             output logic pulse_after);
        @(negedge clk);
        any_pressed = prs;
        key_code    = code;
        scan_tick   = 1'b1;
        @(negedge clk);
        scan_tick   = 1'b0;
        pulse_after = new_key;
        repeat (3) @(negedge clk);
    endtask

    task automatic ticks(input logic prs, input logic [KEY_W-1:0] code, input int n);
        logic p;
        for (int i = 0; i < n; i++) tick_once(prs, code, p);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        logic p;
        logic [KEY_W-1:0] code, other;
        void'($urandom(32'd4242));

        // Reset state (R7).
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset pulse", int'(new_key), 0);
        chk("R7 reset code", int'(captured_key), 0);

        // Press held with no ticks never registers (R2).
        base = pulse_cnt;
        any_pressed = 1'b1; key_code = 4'hA;
        repeat (30) @(negedge clk);
        chk("R2 no tick no pulse", pulse_cnt - base, 0);
        any_pressed = 1'b0;
        ticks(1'b0, 4'h0, N + 1);

        // Short glitch below threshold (R3).
        base = pulse_cnt;
        ticks(1'b1, 4'h5, N - 1);
        ticks(1'b0, 4'h0, N + 1);
        chk("R3 glitch no pulse", pulse_cnt - base, exp_pulses(N - 1));
        chk("R6 code kept after glitch", int'(captured_key), 0);

        // Registration timing and capture (R8, R1).
        base = pulse_cnt;
        ticks(1'b1, 4'h7, N - 1);
        tick_once(1'b1, 4'h7, p);
        chk("R8 pulse right after final tick", int'(p), 1);
        chk("R1 captured code", int'(captured_key), 7);
        chk("R1 one pulse", pulse_cnt - base, 1);

        // Second key while held (R4, R6).
        ticks(1'b1, 4'hC, 5);
        chk("R4 no pulse on second key", pulse_cnt - base, 1);
        chk("R6 code unchanged while held", int'(captured_key), 7);

        // Release bounce shorter than threshold (R5).
        ticks(1'b0, 4'h0, N - 1);
        ticks(1'b1, 4'h7, 1);
        ticks(1'b0, 4'h0, N - 1);
        ticks(1'b1, 4'h3, N + 1);
        chk("R5 release bounce no re-arm", pulse_cnt - base, 1);
        chk("R6 code unchanged after bounce", int'(captured_key), 7);
        ticks(1'b0, 4'h0, N);
        ticks(1'b1, 4'h3, N);
        chk("R5 re-arm after stable release", pulse_cnt - base, 2);
        chk("R1 new code captured", int'(captured_key), 3);
        ticks(1'b0, 4'h0, N + 1);

        // Reset in the middle of a hold (R7).
        ticks(1'b1, 4'h9, N + 2);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R7 mid-hold reset pulse", int'(new_key), 0);
        chk("R7 mid-hold reset code", int'(captured_key), 0);
        base = pulse_cnt;
        ticks(1'b1, 4'h9, N - 1);
        chk("R7 idle after reset", pulse_cnt - base, 0);
        ticks(1'b0, 4'h0, N + 1);

        // Random press episodes with bounce and a second key (R1..R5).
        for (int e = 0; e < 40; e++) begin
            int hold;
            code  = 4'($urandom % 16);
            other = 4'($urandom % 16);
            hold  = N + int'($urandom % 5);
            base  = pulse_cnt;
            if ($urandom % 2 == 1) begin
                ticks(1'b1, code, N - 1);
                ticks(1'b0, 4'h0, 1);
            end
            ticks(1'b1, code, N);
            ticks(1'b1, other, hold - N);
            for (int b = 0; b < int'($urandom % 3); b++) begin
                ticks(1'b0, 4'h0, N - 1);
                ticks(1'b1, other, 1);
            end
            ticks(1'b0, 4'h0, N + 1);
            chk("R4 R5 episode pulse count", pulse_cnt - base, exp_pulses(hold));
            chk("R1 episode code", int'(captured_key), int'(code));
        end

        chk("R1 pulse width", wide_cnt, 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule